// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Flag Register

This block holds the control and status byte of one DMA channel. It keeps two live state bits that the channel engine drives through event pulses: a busy bit, raised when a transaction begins, and a pending bit, raised while a block request waits to be served. It also keeps two sticky flags, transaction-complete and error, which software clears by writing one to their bit positions. Two 2-bit level fields pick the interrupt priority of each flag.

Both flags share a single interrupt request. The output `irq_level` carries the higher of the two active levels. Servicing the interrupt does not clear either flag; only a write-one clear does. When unlimited repeat is selected, the complete flag is raised after every block. Otherwise it is raised only after the block that ends the transaction.

Software reaches the byte through a small synchronous write port and a combinational read port, at a fixed offset inside the channel's register window.

Top module: `dmach_status_regs`

## Requirements
- R1: While reset is asserted and right after it, the register reads 0x00 and `irq_level` is 0.
- R2: Read layout of the byte: bit 7 busy, bit 6 pending, bit 5 error flag, bit 4 complete flag, bits 3:2 error level, bits 1:0 complete level.
- R3: Busy is set by `blk_start` while `ch_enable` is high. It is cleared in the cycle after `ch_enable` is low, after the complete flag is set, or after the error flag is set. A clear overrides a set.
- R4: Pending is set by `blk_req` and cleared by `blk_start` or `ch_abort`. A clear overrides a set.
- R5: `blk_done` sets the complete flag when `blk_last` is high or `rpt_unlimited` is high. Otherwise it leaves the flag unchanged.
- R6: `ch_error` sets the error flag.
- R7: A write with bit 5 or bit 4 at one clears that flag. A zero in those bits has no effect. Write data in bits 7:6 is ignored. Bits 3:0 are stored as written.
- R8: A flag requests an interrupt only while it is set and its level field is nonzero. Acknowledging the interrupt does not change any flag.
- R9: Level encoding is 0 off, 1 low, 2 medium, 3 high. `irq_level` is the larger of the two active levels, or 0 if neither flag is active.
- R10: Writes at any address other than `REG_OFFSET` (default 2) change nothing. Reads there return 0.
- R11: If a hardware set and a write-one clear hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset within the channel window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ch_enable | input | 1 | Channel enable level |
| blk_req | input | 1 | Block request pulse |
| blk_start | input | 1 | Block start pulse |
| blk_done | input | 1 | Block done pulse |
| blk_last | input | 1 | Done block ends the transaction |
| ch_error | input | 1 | Error detected pulse |
| ch_abort | input | 1 | Pending transfer aborted pulse |
| rpt_unlimited | input | 1 | Unlimited repeat selected |
| irq_level | output | 2 | Level of the shared interrupt request |

## Verification
The bench builds the block with its defaults: a 4-bit address, the register at offset 2, and a two-stage reset synchronizer. This puts an in-window offset and a neighbouring offset side by side, so a misdecoded address shows up as a corrupted level field. The two-stage synchronizer sets a fixed three-edge delay after reset release, and the first directed step is timed from that delay. Every level pair that matters for the maximum selection is reached: one flag active, both active with differing levels, a set flag with a zero level, and both levels at the top value.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned N_FLAG   = 2;
  localparam int unsigned BIT_BUSY = 7;
  localparam int unsigned BIT_PEND = 6;
  localparam int unsigned BIT_FLAG = 4; // flag i sits at BIT_FLAG + i

  typedef enum logic [LVL_W-1:0] {
    LVL_OFF = 2'd0,
    LVL_LO  = 2'd1,
    LVL_MED = 2'd2,
    LVL_HI  = 2'd3
  } irq_lvl_e;
endpackage

// File: rtl/dmach_rst_sync.sv
module dmach_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dmach_w1c_flag.sv
module dmach_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/dmach_busy_pend.sv
module dmach_busy_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic req_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic done_set_i,
  input  logic err_set_i,
  output logic busy_o,
  output logic pend_o
);
  logic busy_q, busy_d, pend_q, pend_d;
  logic busy_kill;
  logic pend_kill;

  always_comb begin
    busy_kill = !enable_i || done_set_i || err_set_i;
    pend_kill = start_i || abort_i;
    busy_d = busy_q;
    if (busy_kill)    busy_d = 1'b0;
    else if (start_i) busy_d = 1'b1;
    pend_d = pend_q;
    if (pend_kill)    pend_d = 1'b0;
    else if (req_i)   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
    end
  end

  assign busy_o = busy_q;
  assign pend_o = pend_q;

  p_busy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i || done_set_i || err_set_i) |=> !busy_o);
  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  p_pend_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || abort_i) |=> !pend_o);
  p_pend_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(req_i));
endmodule

// File: rtl/dmach_lvl_max.sv
module dmach_lvl_max
  import dmach_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0]       act_i,
  input  logic [N*LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0]   max_o
);
  always_comb begin
    max_o = LVL_OFF;
    for (int i = 0; i < N; i++) begin
      if (act_i[i] && (lvl_i[i*LVL_W +: LVL_W] > max_o))
        max_o = lvl_i[i*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/dmach_status_regs.sv
module dmach_status_regs
  import dmach_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_OFFSET = 2,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ch_enable,
  input  logic              blk_req,
  input  logic              blk_start,
  input  logic              blk_done,
  input  logic              blk_last,
  input  logic              ch_error,
  input  logic              ch_abort,
  input  logic              rpt_unlimited,
  output logic [LVL_W-1:0]  irq_level
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_OFFSET);
  localparam int unsigned LVL_BITS = N_FLAG * LVL_W;

  logic srst_n;
  logic sel;
  logic wr_hit;
  logic [N_FLAG-1:0]   set_ev;
  logic [N_FLAG-1:0]   flag;
  logic [N_FLAG-1:0]   flag_act;
  logic [LVL_BITS-1:0] lvl_q, lvl_d;
  logic busy, pend;
  logic [REG_W-1:0] reg_val;

  dmach_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n));

  always_comb begin
    sel    = (reg_addr == SEL_ADDR);
    wr_hit = sel && reg_wr;
    set_ev[0] = blk_done && (blk_last || rpt_unlimited); // complete
    set_ev[1] = ch_error;                                // error
  end

  // level fields: clock enable is a write hitting the register
  always_comb begin
    lvl_d = lvl_q;
    if (wr_hit) lvl_d = reg_wdata[LVL_BITS-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    dmach_w1c_flag u_flag (
      .clk(clk), .rst_n(srst_n),
      .set_i(set_ev[g]),
      .clr_i(wr_hit && reg_wdata[BIT_FLAG+g]),
      .flag_o(flag[g]));
    assign flag_act[g] = flag[g] && (lvl_q[g*LVL_W +: LVL_W] != LVL_OFF);
  end

  dmach_busy_pend u_state (
    .clk(clk), .rst_n(srst_n),
    .enable_i(ch_enable), .req_i(blk_req), .start_i(blk_start),
    .abort_i(ch_abort), .done_set_i(set_ev[0]), .err_set_i(set_ev[1]),
    .busy_o(busy), .pend_o(pend));

  dmach_lvl_max #(.N(N_FLAG)) u_max (
    .act_i(flag_act), .lvl_i(lvl_q), .max_o(irq_level));

  always_comb begin
    reg_val = '0;
    reg_val[BIT_BUSY] = busy;
    reg_val[BIT_PEND] = pend;
    reg_val[BIT_FLAG +: N_FLAG] = flag;
    reg_val[LVL_BITS-1:0] = lvl_q;
    reg_rdata = sel ? reg_val : '0;
  end

  p_off_window_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr && !sel) |=> $stable(lvl_q));
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_level != LVL_OFF) |-> (flag != '0));
  p_irq_bound_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (flag_act == '0) |-> (irq_level == LVL_OFF));
  p_lvl_write_r7: assert property (@(posedge clk) disable iff (!srst_n)
    wr_hit |=> (lvl_q == $past(reg_wdata[LVL_BITS-1:0])));
endmodule

// File: tb/test_dmach_status_regs.sv
module test_dmach_status_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic ch_enable, blk_req, blk_start, blk_done, blk_last, ch_error, ch_abort, rpt_unlimited;
  logic [1:0] irq_level;

  int n_chk = 0;
  int n_bad = 0;
  logic t_en = 1'b0;
  logic t_rpt = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic [1:0] irq;
    string      tag;
  } exp_t;
  exp_t sb_q[$];
  exp_t cur;

  always #4 clk = ~clk;

  dmach_status_regs i_dmach_status_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_enable(ch_enable),
    .blk_req(blk_req), .blk_start(blk_start), .blk_done(blk_done),
    .blk_last(blk_last), .ch_error(ch_error), .ch_abort(ch_abort),
    .rpt_unlimited(rpt_unlimited), .irq_level(irq_level));

  task automatic idle();
    reg_addr = 4'd2; reg_wr = 1'b0; reg_wdata = 8'h00;
    {blk_last, ch_abort, ch_error, blk_done, blk_start, blk_req} = 6'b0;
  endtask

  // ev = {last, abort, error, done, start, req}
  task automatic step(input logic [3:0] a, input logic w, input logic [7:0] d,
                      input logic [5:0] ev, input logic [7:0] er,
                      input logic [1:0] ei, input string tag);
    exp_t e;
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_wdata = d;
    ch_enable = t_en; rpt_unlimited = t_rpt;
    {blk_last, ch_abort, ch_error, blk_done, blk_start, blk_req} = ev;
    @(posedge clk);
    #2;
    idle();
    e.rd = er; e.irq = ei; e.tag = tag;
    sb_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #3;
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      n_chk++;
      if (reg_rdata !== cur.rd || irq_level !== cur.irq) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%0d expected rdata=%h irq=%0d",
                 cur.tag, reg_rdata, irq_level, cur.rd, cur.irq);
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    ch_enable = 1'b0; rpt_unlimited = 1'b0;
    #21;
    n_chk++;
    if (reg_rdata !== 8'h00 || irq_level !== 2'd0) begin
      n_bad++;
      $display("FAIL R1 in reset: rdata=%h irq=%0d expected rdata=00 irq=0", reg_rdata, irq_level);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    step(4'd2, 1'b0, 8'h00, 6'b000000, 8'h00, 2'd0, "R1 after reset");
    step(4'd2, 1'b1, 8'hFF, 6'b000000, 8'h0F, 2'd0, "R7 busy/pend write ignored, R2 levels");
    step(4'd2, 1'b1, 8'h06, 6'b000000, 8'h06, 2'd0, "R7 level write");
    t_en = 1'b1;
    step(4'd2, 1'b0, 8'h00, 6'b000001, 8'h46, 2'd0, "R4 pending set");
    step(4'd2, 1'b0, 8'h00, 6'b000010, 8'h86, 2'd0, "R3 busy set, R4 pending clear");
    step(4'd2, 1'b1, 8'hC6, 6'b000000, 8'h86, 2'd0, "R7 write to busy ignored");
    step(4'd2, 1'b0, 8'h00, 6'b000100, 8'h86, 2'd0, "R5 non-last done no flag");
    step(4'd2, 1'b0, 8'h00, 6'b100100, 8'h16, 2'd2, "R5 last done, R3 busy clear, R8 irq");
    step(4'd2, 1'b0, 8'h00, 6'b001000, 8'h36, 2'd2, "R6 error set, R9 max level");
    step(4'd2, 1'b1, 8'h16, 6'b000000, 8'h26, 2'd1, "R7 clear complete only");
    step(4'd3, 1'b1, 8'hFF, 6'b000000, 8'h26, 2'd1, "R10 other offset ignored");
    step(4'd2, 1'b1, 8'h2E, 6'b001000, 8'h2E, 2'd3, "R11 error set wins over clear");
    step(4'd2, 1'b1, 8'h2E, 6'b000000, 8'h0E, 2'd0, "R7 clear error");
    t_rpt = 1'b1;
    step(4'd2, 1'b0, 8'h00, 6'b000001, 8'h4E, 2'd0, "R4 pending again");
    step(4'd2, 1'b0, 8'h00, 6'b000010, 8'h8E, 2'd0, "R3 busy again");
    step(4'd2, 1'b0, 8'h00, 6'b000100, 8'h1E, 2'd2, "R5 repeat sets complete per block");
    step(4'd2, 1'b0, 8'h00, 6'b000010, 8'h9E, 2'd2, "R3 busy on start");
    t_en = 1'b0;
    step(4'd2, 1'b0, 8'h00, 6'b000000, 8'h1E, 2'd2, "R3 busy cleared by disable");
    step(4'd2, 1'b0, 8'h00, 6'b000001, 8'h5E, 2'd2, "R4 pending set");
    step(4'd2, 1'b0, 8'h00, 6'b010000, 8'h1E, 2'd2, "R4 abort clears pending");
    step(4'd2, 1'b1, 8'h1E, 6'b000100, 8'h1E, 2'd2, "R11 complete set wins over clear");
    step(4'd2, 1'b1, 8'h00, 6'b000000, 8'h10, 2'd0, "R8 zero level masks set flag");
    step(4'd2, 1'b0, 8'h00, 6'b000000, 8'h10, 2'd0, "R8 flag persists without clear");
    repeat (3) @(posedge clk);
    #5;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule